// File: doc/BRIEF.md
# Exception Entry Sequencer with Late Arrival

This block decides when one of several pending exception requests is taken and then sequences the entry. Each request line carries a priority, where a lower number is more urgent and a tie goes to the lower exception number. A request qualifies only if its priority is below the mask level. A qualifying request is taken when the core reports base (thread) level, or when it is more urgent than the active priority that the block holds.

On a normal entry the block writes a context frame to a stack memory port. It writes one word per accepted cycle, at descending addresses just below the latched stack pointer, and a ready input stalls it. It then issues a one-cycle vector fetch request. The frame has 8 words, or 26 words when the floating-point frame select is high at entry. When the tail-chain input is high at entry, the block skips the frame and issues the fetch in the next cycle.

A more urgent request can arrive while the frame is being written. The block then retargets the fetch to that request and keeps the word sequence going unchanged. A more urgent request can also arrive after the fetch but before the core reports that the first handler instruction has reached execute. In that case the block issues a second fetch for it and writes no frame. Once that report arrives, any later request is handled as an ordinary nested entry with a full frame. The pending bit of the fetched exception is cleared by a one-hot pulse in the fetch cycle. The active priority takes the fetched exception's priority.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending request whose priority is not strictly below mask_lvl_i is never taken; among the rest, only these are candidates.
- R2: With base_lvl_i=1 any qualifying request is taken. With base_lvl_i=0 a request is taken only if its priority is strictly below act_prio_o. After reset, act_prio_o is all ones.
- R3: The taken request has the lowest priority value among the candidates; on equal values, the lowest exception number wins. Exception i's priority is in prio_i[PW*i +: PW].
- R4: A normal entry writes 8 words with ctx_idx_o = 0,1,2,... and wr_addr_o = sp - 4*(ctx_idx_o+1), using sp_i latched at entry. A word is accepted on a cycle with wr_en_o=1 and wr_ready_i=1. While wr_ready_i=0, wr_en_o stays high and the address holds.
- R5: With fp_frame_i=1 at entry, the frame is 26 words, ending at sp-104.
- R6: With tail_chain_i=1 at entry, no word is written and vec_req_o is high in the cycle after the request is taken.
- R7: A candidate more urgent than the selected exception that appears during stacking becomes the fetched vector. The frame still holds exactly its length in words, and the displaced exception stays pending.
- R8: A more urgent candidate that appears after the fetch and before exec_i causes a second fetch for it, with no frame writes.
- R9: After exec_i, a more urgent request at non-base level is a nested entry with a full frame.
- R10: vec_req_o is a one-cycle pulse, and pend_clr_o is one-hot at vec_idx_o during it and zero otherwise. From the next cycle, act_prio_o holds the fetched exception's priority, and it changes at no other time.
- R11: After reset, wr_en_o=0, vec_req_o=0 and pend_clr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pend_i | input | N | Pending request lines |
| prio_i | input | N*PW | Priority per request, packed by exception number |
| mask_lvl_i | input | PW | Requests must be strictly below this value |
| base_lvl_i | input | 1 | Core is at base (thread) level |
| tail_chain_i | input | 1 | Entry needs no frame |
| fp_frame_i | input | 1 | Use the extended floating-point frame |
| sp_i | input | AW | Current stack pointer |
| ctx_data_i | input | DW | Context word selected by ctx_idx_o |
| wr_ready_i | input | 1 | Stack memory accepts the write |
| exec_i | input | 1 | First handler instruction reached execute |
| wr_en_o | output | 1 | Stack write strobe |
| wr_addr_o | output | AW | Stack write address |
| wr_data_o | output | DW | Stack write data |
| ctx_idx_o | output | CW | Index of the frame word being written |
| vec_req_o | output | 1 | Vector fetch request pulse |
| vec_idx_o | output | IW | Exception number of the fetch |
| pend_clr_o | output | N | One-hot pending clear at fetch |
| act_prio_o | output | PW | Active priority |

## Verification
The hardest situations to reach are the two late-arrival windows. The bench raises a second, more urgent request a few cycles after the first entry starts, while frame words are still going out. In a separate run, it waits for the first fetch pulse and raises the urgent request on the very next cycle, before exec_i. A bench-side pending register is cleared from pend_clr_o, so the displaced request stays pending. That request is then shown to be refused at non-base level against the new active priority.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STACK = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  // a beats b when its priority value is smaller, or equal with a lower number
  function automatic logic more_urgent(input logic [15:0] pa, input logic [15:0] ia,
                                       input logic [15:0] pb, input logic [15:0] ib);
    return (pa < pb) || ((pa == pb) && (ia < ib));
  endfunction

  function automatic int unsigned frame_words(input logic fp, input int unsigned base_n,
                                              input int unsigned extra_n);
    return fp ? (base_n + extra_n) : base_n;
  endfunction

  // word k of the frame sits k+1 words below the stack pointer
  function automatic logic [31:0] word_addr(input logic [31:0] sp, input logic [31:0] k);
    return sp - ((k + 32'd1) << 2);
  endfunction

endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    pend_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [PW-1:0]   mask_lvl_i,
  output logic            best_vld_o,
  output logic [IW-1:0]   best_idx_o,
  output logic [PW-1:0]   best_prio_o
);

  logic [PW-1:0] prio_a [N];
  logic [N-1:0]  elig;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign prio_a[g] = prio_i[PW*g +: PW];
    assign elig[g]   = pend_i[g] && (prio_a[g] < mask_lvl_i);
  end

  always_comb begin
    best_vld_o  = 1'b0;
    best_idx_o  = '0;
    best_prio_o = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!best_vld_o || (prio_a[i] < best_prio_o))) begin
        best_vld_o  = 1'b1;
        best_idx_o  = i[IW-1:0];
        best_prio_o = prio_a[i];
      end
    end
  end

endmodule

// File: rtl/exc_stacker.sv
module exc_stacker
  import exc_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BASE_W   = 8,
  parameter int FP_EXTRA = 18,
  localparam int MAXW    = BASE_W + FP_EXTRA,
  localparam int CW      = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          fp_i,
  input  logic [AW-1:0] sp_i,
  input  logic          wr_ready_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [CW-1:0] ctx_idx_o,
  output logic          done_o
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  logic [AW-1:0] sp_q;
  logic          last_word;
  logic          accept;

  assign last_word = busy_q && (cnt_q == (len_q - CW'(1)));
  assign accept    = busy_q && wr_ready_i;
  assign done_o    = accept && last_word;
  assign wr_en_o   = busy_q;
  assign ctx_idx_o = cnt_q;
  assign wr_addr_o = AW'(word_addr(32'(sp_q), 32'(cnt_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      sp_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= CW'(frame_words(fp_i, BASE_W, FP_EXTRA));
      sp_q   <= sp_i;
    end else if (accept) begin
      if (last_word) busy_q <= 1'b0;
      else           cnt_q  <= cnt_q + CW'(1);
    end
  end

  p_first_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (wr_en_o && (ctx_idx_o == '0)));
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !wr_ready_i && !start_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(ctx_idx_o)));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_word && !start_i) |=>
      (wr_en_o && (wr_addr_o == $past(wr_addr_o) - AW'(4)) && (ctx_idx_o == $past(ctx_idx_o) + CW'(1))));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int N        = 8,
  parameter int PW       = 4,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int BASE_W   = 8,
  parameter int FP_EXTRA = 18,
  localparam int IW      = (N > 1) ? $clog2(N) : 1,
  localparam int CW      = $clog2(BASE_W + FP_EXTRA + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [PW-1:0]   mask_lvl_i,
  input  logic            base_lvl_i,
  input  logic            tail_chain_i,
  input  logic            fp_frame_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   ctx_data_i,
  input  logic            wr_ready_i,
  input  logic            exec_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic [CW-1:0]   ctx_idx_o,
  output logic            vec_req_o,
  output logic [IW-1:0]   vec_idx_o,
  output logic [N-1:0]    pend_clr_o,
  output logic [PW-1:0]   act_prio_o
);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] sel_idx_q;
  logic [PW-1:0] sel_prio_q;
  logic [PW-1:0] act_q;

  logic          best_vld;
  logic [IW-1:0] best_idx;
  logic [PW-1:0] best_prio;

  // named events for the checks
  logic take_evt;
  logic late_evt;
  logic stk_start;
  logic stk_done;
  logic beats_sel;

  exc_pick #(.N(N), .PW(PW)) u_pick (
    .pend_i      (pend_i),
    .prio_i      (prio_i),
    .mask_lvl_i  (mask_lvl_i),
    .best_vld_o  (best_vld),
    .best_idx_o  (best_idx),
    .best_prio_o (best_prio)
  );

  exc_stacker #(.AW(AW), .BASE_W(BASE_W), .FP_EXTRA(FP_EXTRA)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (stk_start),
    .fp_i       (fp_frame_i),
    .sp_i       (sp_i),
    .wr_ready_i (wr_ready_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .ctx_idx_o  (ctx_idx_o),
    .done_o     (stk_done)
  );

  assign wr_data_o = ctx_data_i;

  assign beats_sel = best_vld && more_urgent(16'(best_prio), 16'(best_idx),
                                             16'(sel_prio_q), 16'(sel_idx_q));
  assign take_evt  = (state_q == ST_IDLE) && best_vld &&
                     (base_lvl_i || (best_prio < act_q));
  assign late_evt  = beats_sel &&
                     ((state_q == ST_STACK) || ((state_q == ST_WAIT) && !exec_i));
  assign stk_start = take_evt && !tail_chain_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_evt) state_d = tail_chain_i ? ST_FETCH : ST_STACK;
      ST_STACK: if (stk_done) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_WAIT;
      ST_WAIT:  if (exec_i) state_d = ST_IDLE;
                else if (late_evt) state_d = ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sel_idx_q  <= '0;
      sel_prio_q <= '1;
      act_q      <= '1;
    end else begin
      state_q <= state_d;
      if (take_evt || late_evt) begin
        sel_idx_q  <= best_idx;
        sel_prio_q <= best_prio;
      end
      if (state_q == ST_FETCH) act_q <= sel_prio_q;
    end
  end

  assign vec_req_o  = (state_q == ST_FETCH);
  assign vec_idx_o  = sel_idx_q;
  assign act_prio_o = act_q;

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign pend_clr_o[g] = vec_req_o && (sel_idx_q == IW'(g));
  end

  p_take_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (best_prio < mask_lvl_i));
  p_take_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && !base_lvl_i) |-> (best_prio < act_prio_o));
  p_tail_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && tail_chain_i) |=> (vec_req_o && !wr_en_o));
  p_late_keeps_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (late_evt && wr_en_o && !stk_done) |=> wr_en_o);
  p_wait_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> !wr_en_o);
  p_vec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |=> !vec_req_o);
  p_clr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> ($countones(pend_clr_o) == 1));
  p_clr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_req_o |-> (pend_clr_o == '0));
  p_act_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_req_o |=> $stable(act_prio_o));

endmodule

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;

  localparam int N = 8;
  localparam int PW = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 5;
  localparam int IW = 3;
  localparam logic [31:0] SP = 32'h0000_1000;

  // {base, mask, pend, prio, exp_taken, exp_idx, exp_words}
  localparam int VW = 1 + 4 + 8 + 32 + 1 + 3 + 5;
  localparam int NV = 7;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 4'd15, 8'h01, 32'h2222_2222, 1'b1, 3'd0, 5'd8},
    {1'b1, 4'd15, 8'h0C, 32'h0000_3500, 1'b1, 3'd3, 5'd8},
    {1'b1, 4'd15, 8'h30, 32'h0044_0000, 1'b1, 3'd4, 5'd8},
    {1'b1, 4'd6,  8'h01, 32'h0000_0006, 1'b0, 3'd0, 5'd0},
    {1'b1, 4'd4,  8'h03, 32'h0000_0037, 1'b1, 3'd1, 5'd8},
    {1'b0, 4'd15, 8'h80, 32'hE000_0000, 1'b1, 3'd7, 5'd8},
    {1'b1, 4'd15, 8'hFF, 32'h9182_3456, 1'b1, 3'd6, 5'd8}
  };
  string vtag [NV] = '{"R2", "R3", "R3", "R1", "R1", "R2", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] raise_q = '0;
  logic [N-1:0] done_q;
  logic [N-1:0] pend;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0] mask = 4'd15;
  logic base = 1'b1, tail = 1'b0, fp = 1'b0, exec = 1'b0;
  logic clr = 1'b0, stall_mode = 1'b0;
  logic wr_rdy;
  logic [7:0] lf;

  logic wr_en_o, vec_req_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic [CW-1:0] ctx_idx_o;
  logic [IW-1:0] vec_idx_o;
  logic [N-1:0] pend_clr_o;
  logic [PW-1:0] act_prio_o;

  int total = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign pend = raise_q & ~done_q;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio), .mask_lvl_i(mask),
    .base_lvl_i(base), .tail_chain_i(tail), .fp_frame_i(fp), .sp_i(SP),
    .ctx_data_i(32'hA5A5_0000), .wr_ready_i(wr_rdy), .exec_i(exec),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .ctx_idx_o(ctx_idx_o), .vec_req_o(vec_req_o), .vec_idx_o(vec_idx_o),
    .pend_clr_o(pend_clr_o), .act_prio_o(act_prio_o)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      lf <= 8'h5A;
      wr_rdy <= 1'b1;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      wr_rdy <= stall_mode ? lf[0] : 1'b1;
    end
  end

  // bench-side monitor
  int wr_cnt, fr_cnt, vec_cnt, seq_err, clr_err, stall_err, stalls;
  logic [31:0] first_addr, last_addr, prev_addr;
  logic [IW-1:0] last_vec;
  logic prev_stall;

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      done_q <= '0;
      wr_cnt <= 0; fr_cnt <= 0; vec_cnt <= 0;
      seq_err <= 0; clr_err <= 0; stall_err <= 0; stalls <= 0;
      first_addr <= '0; last_addr <= '0; prev_addr <= '0;
      last_vec <= '0; prev_stall <= 1'b0;
    end else begin
      done_q <= done_q | pend_clr_o;
      if (prev_stall && (!wr_en_o || wr_addr_o != prev_addr)) stall_err <= stall_err + 1;
      prev_stall <= wr_en_o && !wr_rdy;
      prev_addr <= wr_addr_o;
      if (wr_en_o && !wr_rdy) stalls <= stalls + 1;
      if (wr_en_o && wr_rdy) begin
        if (32'(ctx_idx_o) != fr_cnt || wr_addr_o != SP - 32'(4 * (fr_cnt + 1)))
          seq_err <= seq_err + 1;
        if (wr_cnt == 0) first_addr <= wr_addr_o;
        last_addr <= wr_addr_o;
        wr_cnt <= wr_cnt + 1;
        fr_cnt <= fr_cnt + 1;
      end
      if (vec_req_o) begin
        vec_cnt <= vec_cnt + 1;
        last_vec <= vec_idx_o;
        fr_cnt <= 0;
        if (pend_clr_o != (8'b1 << vec_idx_o)) clr_err <= clr_err + 1;
      end else if (pend_clr_o != '0) clr_err <= clr_err + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; raise_q = '0; exec = 1'b0; tail = 1'b0; fp = 1'b0;
    base = 1'b1; mask = 4'd15; stall_mode = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    do_reset();
    // R11 reset state
    chk(wr_en_o == 1'b0, "R11 wr_en after reset", int'(wr_en_o), 0);
    chk(vec_req_o == 1'b0 && pend_clr_o == '0, "R11 vec/clr after reset", int'(vec_req_o), 0);
    chk(act_prio_o == 4'hF, "R2 act_prio after reset", int'(act_prio_o), 15);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      do_reset();
      base = e[53]; mask = e[52:49]; prio = e[40:9];
      raise_q = e[48:41];
      cyc(40);
      chk(vec_cnt == int'(e[8]), {vtag[v], " vector taken"}, vec_cnt, int'(e[8]));
      if (e[8]) chk(last_vec == e[7:5], {vtag[v], " vector index"}, int'(last_vec), int'(e[7:5]));
      chk(wr_cnt == int'(e[4:0]), {vtag[v], " vector words"}, wr_cnt, int'(e[4:0]));
      chk(seq_err == 0 && clr_err == 0, "R10 vector clr/seq", seq_err + clr_err, 0);
    end

    // R4 address order under stalls
    do_reset();
    prio = 32'h0000_0025; stall_mode = 1'b1;
    raise_q = 8'h01;
    cyc(80);
    chk(wr_cnt == 8, "R4 words with stalls", wr_cnt, 8);
    chk(first_addr == SP - 32'd4, "R4 first address", int'(first_addr), int'(SP - 32'd4));
    chk(last_addr == SP - 32'd32, "R4 last address", int'(last_addr), int'(SP - 32'd32));
    chk(seq_err == 0 && stall_err == 0, "R4 order and stall hold", seq_err + stall_err, 0);
    chk(stalls > 0, "R4 stall exercised", stalls, 1);

    // R5 floating-point frame
    do_reset();
    prio = 32'h0000_0025; fp = 1'b1;
    raise_q = 8'h01;
    cyc(60);
    chk(wr_cnt == 26, "R5 extended words", wr_cnt, 26);
    chk(last_addr == SP - 32'd104, "R5 last address", int'(last_addr), int'(SP - 32'd104));
    chk(seq_err == 0, "R5 order", seq_err, 0);

    // R6 tail chain
    do_reset();
    prio = 32'h0000_0300; tail = 1'b1;
    raise_q = 8'h04;
    cyc(1);
    chk(vec_req_o == 1'b1, "R6 fetch next cycle", int'(vec_req_o), 1);
    chk(vec_idx_o == 3'd2, "R6 fetch index", int'(vec_idx_o), 2);
    cyc(20);
    chk(wr_cnt == 0 && vec_cnt == 1, "R6 no frame", wr_cnt, 0);

    // R7 late arrival during stacking
    do_reset();
    prio = 32'h0000_0025;
    raise_q = 8'h01;
    cyc(3);
    raise_q = 8'h03;
    cyc(30);
    chk(vec_cnt == 1 && last_vec == 3'd1, "R7 retargeted vector", int'(last_vec), 1);
    chk(wr_cnt == 8 && seq_err == 0, "R7 frame unchanged", wr_cnt, 8);
    chk(pend[0] == 1'b1, "R7 displaced stays pending", int'(pend[0]), 1);
    chk(act_prio_o == 4'd2, "R10 act_prio after late", int'(act_prio_o), 2);
    base = 1'b0; exec = 1'b1;
    cyc(1);
    exec = 1'b0;
    cyc(20);
    chk(vec_cnt == 1 && wr_cnt == 8, "R2 non-base refusal", vec_cnt, 1);

    // R8 late arrival after fetch, before execute
    do_reset();
    prio = 32'h0000_0025;
    raise_q = 8'h01;
    for (int k = 0; k < 40 && !vec_req_o; k++) cyc(1);
    cyc(1);
    raise_q = 8'h03;
    cyc(20);
    chk(vec_cnt == 2 && last_vec == 3'd1, "R8 second fetch", vec_cnt, 2);
    chk(wr_cnt == 8, "R8 no extra frame", wr_cnt, 8);
    chk(act_prio_o == 4'd2 && clr_err == 0, "R10 act_prio after refetch", int'(act_prio_o), 2);

    // R9 ordinary preemption after execute
    do_reset();
    prio = 32'h0000_0025;
    raise_q = 8'h01;
    cyc(20);
    exec = 1'b1; base = 1'b0;
    cyc(1);
    exec = 1'b0;
    raise_q = 8'h03;
    cyc(30);
    chk(vec_cnt == 2 && last_vec == 3'd1, "R9 nested fetch", vec_cnt, 2);
    chk(wr_cnt == 16 && seq_err == 0, "R9 full second frame", wr_cnt, 16);
    chk(act_prio_o == 4'd2, "R10 act_prio nested", int'(act_prio_o), 2);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule